// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked system read and write an external asynchronous static RAM of 2^19 bytes. The host offers one access at a time on a valid/ready request port: an address, a write flag and a write byte. A read returns its byte with a one-cycle valid pulse, and a write ends with a one-cycle completion pulse. On the memory side the block drives the address lines, the three active-low strobes (chip select, write strobe, output enable) and a byte of outgoing data. A separate enable marks when that data should drive the shared bus, and a separate input carries what the memory drives.

Every phase length is a count of clock cycles. The block derives each count from the clock period and the memory's minimum times in nanoseconds: a ceiling division, never less than one cycle. The address moves only while both chip select and write strobe are high. The block turns on its own bus driver only once the memory's outputs have had time to float after a read. Between accesses the memory is held in standby, with chip select high.

Top module: `sram_seq_ctrl`

## Requirements
- R1: Whenever the block is idle, including straight after reset, chip select, write strobe and output enable are all high (1), the bus driver is off and `req_ready` is 1.
- R2: `mem_addr` changes only at an edge where chip select and write strobe were high before the edge and are still high after it.
- R3: A read holds chip select and output enable low (0) and the write strobe high for N_RD cycles. N_RD is the ceiling of the largest of the read cycle, address access, chip-select access and output-enable access times, divided by the clock period (7 at the defaults). The byte on `mem_dq_in` in the last of these cycles appears on `rd_data`. `rd_valid` is high for exactly one cycle, N_RD+1 cycles after the accepting edge.
- R4: A write holds chip select and write strobe low, output enable high and the driver on for N_WR cycles, with the write byte steady on `mem_dq_out` the whole time. N_WR is the ceiling of the largest of the write cycle, pulse width, address-to-end, select-to-end and data setup times, divided by the period (7 at the defaults). When no turnaround wait applies, `wr_done` pulses for one cycle N_WR+2 cycles after the accepting edge.
- R5: The driver stays on for the one cycle after the strobes rise at the end of a write, which gives data hold. It is off by the time the block is idle again.
- R6: After a read ends, the driver stays off for at least N_HZ = ceil(T_HZ/period) cycles (3 at the defaults). A write that follows a read starts its strobe at the later of (its accept edge + 1) and (the read-end edge + N_HZ).
- R7: `req_ready` is 0 from the accepting edge until the access's result pulse.
- R8: The driver is never on while output enable is low, and output enable stays high for the whole of every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Block can accept an access this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the access |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a read result |
| rd_data | output | 8 | Byte returned by the last read |
| wr_done | output | 1 | One-cycle pulse: a write has finished |
| mem_addr | output | 19 | Address lines to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte the block places on the data bus |
| mem_dq_oe | output | 1 | 1 = block drives the data bus |
| mem_dq_in | input | 8 | Byte the memory places on the data bus |

## Verification
The assertions assume the host raises `req_valid` only when `req_ready` is high. They also assume the host keeps the address and data steady during that one cycle. The bench's driver task waits for ready at a falling edge and drops the request after the accepting edge, so it stays within those assumptions. The assertions also assume that only the memory model drives `mem_dq_in`. The model drives it only while a read is open, and it flags any ordering the memory would reject: too short a pulse or read, data not set up long enough, an address move under a low strobe, or the driver turned on while the memory could still be driving.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_TURN  = 3'd2,
        ST_READ  = 3'd3,
        ST_WRITE = 3'd4,
        ST_RECOV = 3'd5
    } ctl_state_e;

    // Cycles needed to cover t_ns at a clock of clk_ns, at least one.
    function automatic int unsigned wait_cycles(input int unsigned t_ns,
                                                input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_of(input int unsigned a,
                                           input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_bus_guard.sv
module sram_bus_guard #(
    parameter int unsigned N_HZ = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic release_i,   // read strobes released this edge
    output logic write_ok_o,  // driver may turn on at the coming edge
    output logic quiet_o      // float window fully elapsed
);
    localparam int unsigned HW = $clog2(N_HZ + 1);

    logic [HW-1:0] hz_d, hz_q;

    always_comb begin
        hz_d = hz_q;
        if (release_i)
            hz_d = HW'(N_HZ);
        else if (hz_q != '0)
            hz_d = hz_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hz_q <= '0;
        else        hz_q <= hz_d;
    end

    assign write_ok_o = (hz_q <= HW'(1));
    assign quiet_o    = (hz_q == '0);

    AST_GUARD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hz_q <= HW'(N_HZ)); // R6

    AST_GUARD_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!release_i && hz_q != '0) |=> (hz_q == $past(hz_q) - 1'b1)); // R6

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] data_d, data_q;
    logic          vld_d, vld_q;

    always_comb begin
        data_d = take ? din : data_q;
        vld_d  = take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign rdata  = data_q;
    assign rvalid = vld_q;

    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q); // R3

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_RC_NS       = 55,
    parameter int unsigned T_AA_NS       = 55,
    parameter int unsigned T_ACE_NS      = 55,
    parameter int unsigned T_OE_NS       = 30,
    parameter int unsigned T_HZ_NS       = 20,
    parameter int unsigned T_WC_NS       = 55,
    parameter int unsigned T_WP_NS       = 45,
    parameter int unsigned T_AW_NS       = 50,
    parameter int unsigned T_CW_NS       = 50,
    parameter int unsigned T_DW_NS       = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Phase lengths in cycles
    localparam int unsigned N_RD = max_of(
        max_of(wait_cycles(T_RC_NS, CLK_PERIOD_NS), wait_cycles(T_AA_NS, CLK_PERIOD_NS)),
        max_of(wait_cycles(T_ACE_NS, CLK_PERIOD_NS), wait_cycles(T_OE_NS, CLK_PERIOD_NS)));
    localparam int unsigned N_WR = max_of(
        max_of(max_of(wait_cycles(T_WC_NS, CLK_PERIOD_NS), wait_cycles(T_WP_NS, CLK_PERIOD_NS)),
               max_of(wait_cycles(T_AW_NS, CLK_PERIOD_NS), wait_cycles(T_CW_NS, CLK_PERIOD_NS))),
        wait_cycles(T_DW_NS, CLK_PERIOD_NS));
    localparam int unsigned N_HZ  = wait_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int unsigned N_MAX = max_of(N_RD, N_WR);
    localparam int unsigned CW    = $clog2(N_MAX + 1);

    typedef struct packed {
        ctl_state_e        state;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic              is_wr;
        logic              wdone;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          cap_take;
    logic          hz_release;
    logic          write_ok;
    logic          bus_quiet;

    sram_wait_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_bus_guard #(.N_HZ(N_HZ)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .release_i  (hz_release),
        .write_ok_o (write_ok),
        .quiet_o    (bus_quiet)
    );

    sram_rd_capture #(.DW(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (cap_take),
        .din    (mem_dq_in),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.wdone = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        cap_take   = 1'b0;
        hz_release = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.is_wr = req_we;
                    ctl_d.state = ST_SETUP;
                end
            end
            ST_SETUP, ST_TURN: begin
                if (!ctl_q.is_wr) begin
                    ctl_d.state = ST_READ;
                    ctl_d.ce_n  = 1'b0;
                    ctl_d.oe_n  = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(N_RD - 1);
                end else if (write_ok) begin
                    ctl_d.state = ST_WRITE;
                    ctl_d.ce_n  = 1'b0;
                    ctl_d.we_n  = 1'b0;
                    ctl_d.drv   = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(N_WR - 1);
                end else begin
                    ctl_d.state = ST_TURN;
                end
            end
            ST_READ: begin
                if (tmr_expired) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                    cap_take    = 1'b1;
                    hz_release  = 1'b1;
                end
            end
            ST_WRITE: begin
                if (tmr_expired) begin
                    ctl_d.state = ST_RECOV;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.we_n  = 1'b1;
                end
            end
            ST_RECOV: begin
                ctl_d.state = ST_IDLE;
                ctl_d.drv   = 1'b0;
                ctl_d.wdone = 1'b1;
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.ce_n  = 1'b1;
                ctl_d.we_n  = 1'b1;
                ctl_d.oe_n  = 1'b1;
                ctl_d.drv   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.ce_n  <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign wr_done    = ctl_q.wdone;
    assign mem_addr   = ctl_q.addr;
    assign mem_ce_n   = ctl_q.ce_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.drv;

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1

    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |->
            (mem_ce_n && mem_we_n && $past(mem_ce_n) && $past(mem_we_n))); // R2

    AST_WRITE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe)); // R4

    AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_out)); // R4

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe); // R5

    AST_TURN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> bus_quiet); // R6

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R7

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R8

endmodule

// File: tb/sram_seq_ctrl_tb.sv
module sram_seq_ctrl_tb;
    localparam int PER  = 8;
    localparam int T_AA = 55;
    localparam int T_WP = 45;
    localparam int T_DW = 25;

    function automatic int cdiv(input int t, input int p);
        int c;
        c = (t + p - 1) / p;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_RD = 7;   // ceil(55/8)
    localparam int E_WR = 7;   // ceil(55/8)
    localparam int E_HZ = 3;   // ceil(20/8)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        wr_done;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in = 8'h00;

    always #4 clk = ~clk;

    sram_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [int];
    int v_addr = 0, v_float = 0, v_wr = 0, v_hold = 0, v_cont = 0;
    int rd_run = 0, wr_run = 0, dstab = 0, flt = 0;
    logic [18:0] p_addr = '0;
    logic p_ce = 1'b1, p_we = 1'b1, p_wr = 1'b0;
    logic [7:0] p_dout = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic rd_c, wr_c;
            rd_c = !mem_ce_n && !mem_oe_n && mem_we_n;
            wr_c = !mem_ce_n && !mem_we_n;
            if (mem_addr != p_addr && !(mem_ce_n && mem_we_n && p_ce && p_we)) v_addr++;
            if (mem_dq_oe && !mem_oe_n) v_cont++;
            if (wr_c && mem_dq_oe && !mem_oe_n) v_cont++;
            if (rd_c) begin
                rd_run++;
                flt = E_HZ;
                mem_dq_in <= (rd_run * PER >= T_AA)
                    ? (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00) : 8'hEE;
            end else begin
                rd_run = 0;
                mem_dq_in <= 8'h00;
                if (mem_dq_oe && flt > 0) v_float++;
                if (flt > 0) flt--;
            end
            if (wr_c) begin
                wr_run++;
                if (!mem_dq_oe) dstab = 0;
                else if (p_wr && mem_dq_out == p_dout) dstab++;
                else dstab = 1;
            end else if (p_wr) begin
                if (wr_run * PER < T_WP || dstab * PER < T_DW) v_wr++;
                if (!mem_dq_oe) v_hold++;
                mem[int'(mem_addr)] = p_dout;
                wr_run = 0;
            end
            p_addr = mem_addr; p_ce = mem_ce_n; p_we = mem_we_n;
            p_wr = wr_c; p_dout = mem_dq_out;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         is_wr;
        logic [7:0] data;
        int         acc;
        int         lat;
    } item_t;
    item_t q[$];
    logic [7:0] shadow [int];
    int last_rd_end = -100;

    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        it.acc = cyc;
        it.is_wr = wr;
        if (wr) begin
            int entry;
            entry = (it.acc + 1 > last_rd_end + E_HZ) ? it.acc + 1 : last_rd_end + E_HZ;
            it.lat = entry + E_WR + 1 - it.acc;
            it.data = d;
            shadow[int'(a)] = d;
        end else begin
            it.lat = E_RD + 1;
            it.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
            last_rd_end = it.acc + E_RD + 1;
        end
        q.push_back(it);
        // R7: ready is low right after the accepting edge
        check(req_ready == 1'b0, "R7 ready during access", req_ready, 0);
    endtask

    always @(negedge clk) begin
        if (rst_n && (rd_valid || wr_done)) begin
            if (q.size() == 0) begin
                check(1'b0, "R3/R4 unexpected result pulse", 1, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                if (it.is_wr) begin
                    check(wr_done && !rd_valid, "R4 write completion kind", wr_done, 1);
                    check(cyc - it.acc == it.lat, (it.lat == E_WR + 2) ? "R4 write latency" :
                          "R6 write-after-read latency", cyc - it.acc, it.lat);
                end else begin
                    check(rd_valid && !wr_done, "R3 read result kind", rd_valid, 1);
                    check(cyc - it.acc == it.lat, "R3 read latency", cyc - it.acc, it.lat);
                    check(rd_data == it.data, "R3 read data", rd_data, it.data);
                end
            end
        end
    end

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high after reset",
              {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        check(!mem_dq_oe, "R1 driver off after reset", mem_dq_oe, 0);
        check(req_ready, "R1 ready after reset", req_ready, 1);

        // R4 writes with several data patterns, boundary addresses
        issue(1'b1, 19'h00000, 8'hA5);
        issue(1'b1, 19'h7FFFF, 8'h5A);
        issue(1'b1, 19'h12345, 8'hFF);
        issue(1'b1, 19'h40000, 8'h00);
        // R3 reads back
        issue(1'b0, 19'h7FFFF, 8'h00);
        issue(1'b0, 19'h00000, 8'h00);
        issue(1'b0, 19'h12345, 8'h00);
        issue(1'b0, 19'h00777, 8'h00);   // never written
        drain();

        // R6: write right after a read waits for the bus to float
        issue(1'b0, 19'h40000, 8'h00);
        issue(1'b1, 19'h40000, 8'h3C);
        issue(1'b0, 19'h40000, 8'h00);
        // R6: same again, overwriting a cell just read
        issue(1'b0, 19'h00000, 8'h00);
        issue(1'b1, 19'h00000, 8'hC3);
        issue(1'b1, 19'h00001, 8'h81);
        issue(1'b0, 19'h00000, 8'h00);
        issue(1'b0, 19'h00001, 8'h00);
        drain();

        // R1: standby after traffic
        repeat (5) @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
              "R1 standby between accesses", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

        check(v_addr == 0, "R2 address moved under a low strobe", v_addr, 0);
        check(v_wr == 0, "R4 write pulse or data setup too short", v_wr, 0);
        check(v_hold == 0, "R5 driver dropped with the strobe", v_hold, 0);
        check(v_float == 0, "R6 driver on inside the float window", v_float, 0);
        check(v_cont == 0, "R8 driver on while output enable low", v_cont, 0);
        check(cdiv(T_AA, PER) == E_RD, "R3 read count", cdiv(T_AA, PER), E_RD);

        finished = 1'b1;
        summary();
    end

endmodule